// File: doc/BRIEF.md
# Debug Breakpoint Comparator Unit

This unit watches the instruction-fetch address and the data-memory access address of a small 8-bit processor core. It compares both against a bank of four breakpoint resources and raises a halt request for the core's debug logic when one of them matches. Two resources always compare against the program address. The other two are shared, and a mode field chooses what they do: two exact data-address breakpoints, one masked program-address range, or one masked data-address range.

A debug host loads the breakpoint values, the per-resource enable bits and the mode through a simple synchronous write port. A sticky 4-bit status field records which resource matched, and the halt request stays high while any status bit is set. Matches count only while both the debug-enable and scan-port-enable inputs are high and no lock bit is set, so a locked device gives no debug access.

Top module: `bkpt_unit`

## Requirements
- R1: After a synchronous reset, `hit_status` is 0, `halt_req` is 0, all four enable bits are cleared (no access can match) and the split mode (mode 0) is selected.
- R2: Resources 0 and 1 compare `fetch_addr` exactly with the program values written at register addresses 0 and 1. They set status bits 0 and 1 only on cycles with `fetch_valid` high.
- R3: In mode 0 (control bits [5:4] = 0), resources 2 and 3 compare `dmem_addr` exactly with the values at register addresses 2 and 3. They set status bits 2 and 3.
- R4: In mode 1, register 2 holds a program address and register 3 holds a mask (low 13 bits). A fetch matches when ((fetch_addr XOR value) AND mask) == 0, so a mask bit of 1 means that bit is compared. The match sets status bit 2, and status bit 3 is never set.
- R5: In mode 2, the same masked rule applies to `dmem_addr` with all 16 bits of registers 2 and 3. The match sets status bit 2, and status bit 3 is never set.
- R6: Control register (address 4) bits [3:0] enable resources 0 to 3 one by one. A disabled resource never sets its status bit.
- R7: Data resources are evaluated only when `dmem_rd` or `dmem_wr` is high. Program resources are evaluated only when `fetch_valid` is high.
- R8: No status bit is set unless both `dbg_en` and `jtag_en` are high.
- R9: If any bit of `lock_bits` is set, no status bit is set, whatever the enables are.
- R10: A match is seen on `hit_status` and `halt_req` at the first clock edge after the matching access, and not before it.
- R11: Status bits are sticky. A write to register address 5 clears each status bit whose data bit is 1, but a new match in the same cycle wins over the clear. `halt_req` is high exactly while `hit_status` is nonzero.
- R12: Mode value 3 behaves like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | PC_W | Program word address of the fetch |
| dmem_rd | input | 1 | Data read strobe |
| dmem_wr | input | 1 | Data write strobe |
| dmem_addr | input | DA_W | Data-memory address |
| dbg_en | input | 1 | Debug system enable |
| jtag_en | input | 1 | Scan test port enable |
| lock_bits | input | LOCK_W | Device lock bits; any set bit blocks matches |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0,1 program values; 2,3 shared values; 4 control; 5 status clear) |
| wr_data | input | DA_W | Register write data |
| hit_status | output | 4 | Sticky per-resource match flags |
| halt_req | output | 1 | Halt request to the core |

## Verification
In the split mode, every data address is swept with read and write strobes taking turns. This shows that only the two programmed addresses hit, that each sets its own bit, and that both strobe kinds are accepted. In the program-range mode, every fetch address is swept while data reads run alongside. This separates masked from unmasked bits and shows that the data side is ignored in that mode. In the data-range mode, every data address is swept with a repeating read/write/idle strobe pattern, which separates the range boundaries from strobe gating. Directed cases then take each gating input, each lock bit and each enable away one at a time, and step the clear sequence of several sticky bits.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'd0,
    MODE_PRANGE = 2'd1,
    MODE_DRANGE = 2'd2,
    MODE_ALT    = 2'd3
  } bk_mode_e;

  localparam int NSLOT = 4;
  localparam int RA_W  = 3;

  localparam logic [RA_W-1:0] RA_PV0  = 3'd0;
  localparam logic [RA_W-1:0] RA_PV1  = 3'd1;
  localparam logic [RA_W-1:0] RA_SV0  = 3'd2;
  localparam logic [RA_W-1:0] RA_SV1  = 3'd3;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd4;
  localparam logic [RA_W-1:0] RA_STAT = 3'd5;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic         hit
);
  // A mask bit of 1 makes that address bit take part in the compare
  assign hit = (((addr ^ value) & mask) == '0);
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int DA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [RA_W-1:0]            wr_addr,
  input  logic [DA_W-1:0]            wr_data,
  output logic [1:0][PC_W-1:0]       pval,
  output logic [1:0][DA_W-1:0]       sval,
  output logic [NSLOT-1:0]           en,
  output bk_mode_e                   mode,
  output logic [NSLOT-1:0]           clr_mask
);
  for (genvar g = 0; g < 2; g++) begin : g_pv
    always_ff @(posedge clk) begin
      if (rst)
        pval[g] <= '0;
      else if (wr_en && wr_addr == (RA_PV0 + RA_W'(g)))
        pval[g] <= wr_data[PC_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)
        sval[g] <= '0;
      else if (wr_en && wr_addr == (RA_SV0 + RA_W'(g)))
        sval[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      mode <= MODE_SPLIT;
    end else if (wr_en && wr_addr == RA_CTRL) begin
      en   <= wr_data[NSLOT-1:0];
      mode <= bk_mode_e'(wr_data[NSLOT+1:NSLOT]);
    end
  end

  assign clr_mask = (wr_en && wr_addr == RA_STAT) ? wr_data[NSLOT-1:0] : '0;
endmodule

// File: rtl/bkpt_route.sv
module bkpt_route
  import bkpt_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int DA_W = 16
) (
  input  logic                 fetch_valid,
  input  logic [PC_W-1:0]      fetch_addr,
  input  logic                 dmem_acc,
  input  logic [DA_W-1:0]      dmem_addr,
  input  logic [1:0][PC_W-1:0] pval,
  input  logic [1:0][DA_W-1:0] sval,
  input  logic [NSLOT-1:0]     en,
  input  bk_mode_e             mode,
  output logic [NSLOT-1:0]     raw_hit
);
  localparam logic [PC_W-1:0] P_ALL = {PC_W{1'b1}};
  localparam logic [DA_W-1:0] D_ALL = {DA_W{1'b1}};

  logic [1:0] p_eq;
  logic [1:0] d_eq;
  logic       p_rng;
  logic       d_rng;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    bkpt_cmp #(.W(PC_W)) u_p (
      .addr(fetch_addr), .value(pval[g]), .mask(P_ALL), .hit(p_eq[g])
    );
    bkpt_cmp #(.W(DA_W)) u_d (
      .addr(dmem_addr), .value(sval[g]), .mask(D_ALL), .hit(d_eq[g])
    );
  end

  bkpt_cmp #(.W(PC_W)) u_prng (
    .addr(fetch_addr), .value(sval[0][PC_W-1:0]), .mask(sval[1][PC_W-1:0]), .hit(p_rng)
  );
  bkpt_cmp #(.W(DA_W)) u_drng (
    .addr(dmem_addr), .value(sval[0]), .mask(sval[1]), .hit(d_rng)
  );

  always_comb begin
    raw_hit[0] = fetch_valid & en[0] & p_eq[0];
    raw_hit[1] = fetch_valid & en[1] & p_eq[1];
    case (mode)
      MODE_PRANGE: begin
        raw_hit[2] = fetch_valid & en[2] & p_rng;
        raw_hit[3] = 1'b0;
      end
      MODE_DRANGE: begin
        raw_hit[2] = dmem_acc & en[2] & d_rng;
        raw_hit[3] = 1'b0;
      end
      default: begin
        raw_hit[2] = dmem_acc & en[2] & d_eq[0];
        raw_hit[3] = dmem_acc & en[3] & d_eq[1];
      end
    endcase
  end
endmodule

// File: rtl/bkpt_status.sv
module bkpt_status
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] raw_hit,
  input  logic             gate_open,
  input  logic [NSLOT-1:0] clr_mask,
  output logic [NSLOT-1:0] status,
  output logic             halt
);
  logic [NSLOT-1:0] stat_nxt;

  // New hits win over a clear of the same bit
  assign stat_nxt = (status & ~clr_mask) | (gate_open ? raw_hit : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      halt   <= 1'b0;
    end else begin
      status <= stat_nxt;
      halt   <= |stat_nxt;
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int DA_W   = 16,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_addr,
  input  logic              dmem_rd,
  input  logic              dmem_wr,
  input  logic [DA_W-1:0]   dmem_addr,
  input  logic              dbg_en,
  input  logic              jtag_en,
  input  logic [LOCK_W-1:0] lock_bits,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DA_W-1:0]   wr_data,
  output logic [3:0]        hit_status,
  output logic              halt_req
);
  logic [1:0][PC_W-1:0] pval;
  logic [1:0][DA_W-1:0] sval;
  logic [NSLOT-1:0]     en;
  bk_mode_e             mode;
  logic [NSLOT-1:0]     clr_mask;
  logic [NSLOT-1:0]     raw_hit;
  logic                 gate_open;

  assign gate_open = dbg_en & jtag_en & ~(|lock_bits);

  bkpt_regs #(.PC_W(PC_W), .DA_W(DA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pval(pval), .sval(sval), .en(en), .mode(mode), .clr_mask(clr_mask)
  );

  bkpt_route #(.PC_W(PC_W), .DA_W(DA_W)) u_route (
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .dmem_acc(dmem_rd | dmem_wr), .dmem_addr(dmem_addr),
    .pval(pval), .sval(sval), .en(en), .mode(mode), .raw_hit(raw_hit)
  );

  bkpt_status u_stat (
    .clk(clk), .rst(rst), .raw_hit(raw_hit), .gate_open(gate_open),
    .clr_mask(clr_mask), .status(hit_status), .halt(halt_req)
  );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int LOCK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              dmem_rd,
  input logic              dmem_wr,
  input logic              dbg_en,
  input logic              jtag_en,
  input logic [LOCK_W-1:0] lock_bits,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [3:0]        hit_status,
  input logic              halt_req
);
  logic stat_wr;
  assign stat_wr = wr_en && (wr_addr == 3'd5);

  assert_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (|lock_bits && !stat_wr) |=> $stable(hit_status));

  assert_dbg_R8: assert property (@(posedge clk) disable iff (rst)
    (!dbg_en && !stat_wr) |=> $stable(hit_status));

  assert_jtag_R8: assert property (@(posedge clk) disable iff (rst)
    (!jtag_en && !stat_wr) |=> $stable(hit_status));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !dmem_rd && !dmem_wr && !stat_wr) |=> $stable(hit_status));

  assert_halt_R11: assert property (@(posedge clk) disable iff (rst)
    halt_req == (hit_status != 4'd0));
endmodule

bind bkpt_unit bkpt_unit_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .dmem_rd(dmem_rd),
  .dmem_wr(dmem_wr), .dbg_en(dbg_en), .jtag_en(jtag_en), .lock_bits(lock_bits),
  .wr_en(wr_en), .wr_addr(wr_addr), .hit_status(hit_status), .halt_req(halt_req)
);

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [12:0] fetch_addr = '0;
  logic        dmem_rd = 1'b0;
  logic        dmem_wr = 1'b0;
  logic [15:0] dmem_addr = '0;
  logic        dbg_en = 1'b1;
  logic        jtag_en = 1'b1;
  logic [1:0]  lock_bits = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  hit_status;
  logic        halt_req;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bkpt_unit u0 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
    .dbg_en(dbg_en), .jtag_en(jtag_en), .lock_bits(lock_bits),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_status(hit_status), .halt_req(halt_req)
  );

  task automatic check(input string req, input logic [3:0] exp_s);
    logic exp_h;
    exp_h = |exp_s;
    total++;
    if (hit_status !== exp_s || halt_req !== exp_h) begin
      bad++;
      $display("FAIL %s: status=%b halt=%b expected status=%b halt=%b",
               req, hit_status, halt_req, exp_s, exp_h);
    end
  endtask

  task automatic regw(input logic [2:0] a, input logic [15:0] d);
    fetch_valid = 1'b0; dmem_rd = 1'b0; dmem_wr = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic cyc(input logic fv, input logic [12:0] fa, input logic rd,
                     input logic wrs, input logic [15:0] da, input logic clr);
    fetch_valid = fv; fetch_addr = fa;
    dmem_rd = rd; dmem_wr = wrs; dmem_addr = da;
    wr_en = clr; wr_addr = 3'd5; wr_data = 16'h000F;
    @(posedge clk); #2;
    fetch_valid = 1'b0; dmem_rd = 1'b0; dmem_wr = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    check("R1 reset state", 4'b0000);
    // values are zero after reset, but enables are cleared
    cyc(1'b1, 13'h0000, 1'b1, 1'b0, 16'h0000, 1'b0);
    check("R1 enables cleared", 4'b0000);

    regw(3'd0, 16'h0123);
    regw(3'd1, 16'h1FFF);
    regw(3'd4, 16'h0003);
    // R10: not visible before the edge
    fetch_valid = 1'b1; fetch_addr = 13'h0123;
    #5 check("R10 no early hit", 4'b0000);
    @(posedge clk); #2;
    fetch_valid = 1'b0;
    check("R2 R10 prog slot 0 hit", 4'b0001);
    regw(3'd5, 16'h0001);
    check("R11 clear releases halt", 4'b0000);
    cyc(1'b0, 13'h1FFF, 1'b0, 1'b0, 16'h0000, 1'b0);
    check("R7 no fetch strobe", 4'b0000);
    cyc(1'b1, 13'h1FFF, 1'b0, 1'b0, 16'h0000, 1'b0);
    check("R2 prog slot 1 hit", 4'b0010);
    regw(3'd5, 16'h000F);

    // R8 / R9 gating
    dbg_en = 1'b0;
    cyc(1'b1, 13'h0123, 1'b0, 1'b0, 16'h0000, 1'b0);
    check("R8 dbg_en low", 4'b0000);
    dbg_en = 1'b1; jtag_en = 1'b0;
    cyc(1'b1, 13'h0123, 1'b0, 1'b0, 16'h0000, 1'b0);
    check("R8 jtag_en low", 4'b0000);
    jtag_en = 1'b1;
    for (int l = 1; l < 4; l++) begin
      lock_bits = 2'(l);
      cyc(1'b1, 13'h0123, 1'b0, 1'b0, 16'h0000, 1'b0);
      check("R9 lock set", 4'b0000);
    end
    lock_bits = 2'b00;
    cyc(1'b1, 13'h0123, 1'b0, 1'b0, 16'h0000, 1'b0);
    check("R8 R9 gates open", 4'b0001);

    // R11 sticky and partial clear
    regw(3'd2, 16'h0040);
    regw(3'd3, 16'h0077);
    regw(3'd4, 16'h000B);
    cyc(1'b0, 13'h0000, 1'b1, 1'b0, 16'h0077, 1'b0);
    check("R11 sticky accumulate", 4'b1001);
    regw(3'd5, 16'h0001);
    check("R11 partial clear keeps halt", 4'b1000);
    cyc(1'b0, 13'h0000, 1'b1, 1'b0, 16'h0040, 1'b0);
    check("R6 slot 2 disabled", 4'b1000);
    regw(3'd5, 16'h0008);
    check("R11 full clear", 4'b0000);

    // R3: split mode, every data address, read/write alternating
    regw(3'd2, 16'hABCD);
    regw(3'd3, 16'h0040);
    regw(3'd4, 16'h000F);
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] da;
      da = 16'(a);
      cyc(1'b0, 13'h0000, ~da[0], da[0], da, 1'b1);
      check("R3 split data sweep", {da == 16'h0040, da == 16'hABCD, 2'b00});
    end

    // R4: program range, every fetch address, data reads alongside
    regw(3'd2, 16'h0A40);
    regw(3'd3, 16'h1FC0);
    regw(3'd4, 16'h001F);
    for (int a = 0; a < 8192; a++) begin
      logic [12:0] fa;
      fa = 13'(a);
      cyc(1'b1, fa, 1'b1, 1'b0, 16'(a), 1'b1);
      check("R4 program range sweep",
            {1'b0, ((fa ^ 13'h0A40) & 13'h1FC0) == 13'h0, fa == 13'h1FFF, fa == 13'h0123});
    end

    // R5 / R7: data range, read/write/idle pattern
    regw(3'd2, 16'h8000);
    regw(3'd3, 16'hF000);
    regw(3'd4, 16'h002F);
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] da;
      logic        rd;
      logic        wrs;
      da  = 16'(a);
      rd  = (a % 3) == 0;
      wrs = (a % 3) == 1;
      cyc(1'b0, 13'h0000, rd, wrs, da, 1'b1);
      check("R5 R7 data range sweep",
            {1'b0, (rd | wrs) && ((da & 16'hF000) == 16'h8000), 2'b00});
    end

    // R12: mode 3 acts as split
    regw(3'd4, 16'h003F);
    cyc(1'b0, 13'h0000, 1'b0, 1'b1, 16'hF000, 1'b1);
    check("R12 alt mode exact slot 3", 4'b1000);
    cyc(1'b0, 13'h0000, 1'b1, 1'b0, 16'h8005, 1'b1);
    check("R12 alt mode no range", 4'b0000);

    // R6: per-slot enables
    regw(3'd4, 16'h000B);
    cyc(1'b0, 13'h0000, 1'b1, 1'b0, 16'h8000, 1'b1);
    check("R6 slot 2 disabled", 4'b0000);
    cyc(1'b0, 13'h0000, 1'b1, 1'b0, 16'hF000, 1'b1);
    check("R6 slot 3 enabled", 4'b1000);
    regw(3'd4, 16'h0002);
    cyc(1'b1, 13'h0123, 1'b0, 1'b0, 16'h0000, 1'b1);
    check("R6 slot 0 disabled", 4'b0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule